// File: doc/BRIEF.md
# Nibble Stream Elastic FIFO

This block carries a 4-bit media-independent receive stream from one clock-enable domain into another on the same clock, with no MAC in between. Words come in on the receive enable and go out on the transmit enable. The two enables run at slightly different average rates. To cover that drift, the block holds back the start of each outgoing frame until a margin of words has built up. Any short-term surplus or deficit during the frame is then taken up by a small register-based queue.

Each stored entry carries a nibble, a valid bit and an error bit. When the receive valid falls, one extra entry with its valid bit clear is stored. This end marker closes the frame, so the output side knows where to stop. When a frame ends, the output goes idle, and the next frame must again build up its margin before it is sent.

Problems in the frame are reported in-band on the output error line. If the queue runs dry in mid-frame, the error line is raised for the rest of that frame. If the queue is too full to take a word, that word is lost and the frame is marked corrupt.

Top module: `mii_elastic_fifo`

## Requirements
- R1: A synchronous reset (`rst` high) empties the queue: `fill` reads 0, and `txValid` and `txErr` read 0 after the clock edge.
- R2: A word is stored only on a cycle with `rxCe` high. With `rxCe` low, `rxValid`, `rxErr` and `rxData` have no effect, and `fill` does not change.
- R3: At the start of a frame, `txValid` stays low on every `txCe` while `fill` is below `WATERMARK`. Once the frame has started, one stored nibble is presented per `txCe`, in arrival order. The outputs change only on an edge where `txCe` is high.
- R4: A frame whose end marker is already stored starts on the next `txCe`, even if `fill` is below `WATERMARK`.
- R5: On the first `rxCe` with `rxValid` low after a valid word, one end-marker entry is stored, and it counts in `fill`. Idle words after that are not stored. When the marker is reached on a `txCe`, `txValid` and `txErr` go low, `txData` reads 0, and the marker entry is removed.
- R6: If a frame is running and the queue is empty on a `txCe`, the output reads `txValid`=1, `txErr`=1 and `txData`=0. Every later nibble of that frame leaves with `txErr`=1.
- R7: A data word is stored only while the occupancy, after any same-cycle removal, is below `DEPTH`-1. The last slot is kept for the end marker. A data word that does not fit is dropped, and the error bit of the newest stored entry is set.
- R8: When a word is stored and one is removed on the same edge, `fill` does not change.
- R9: `rxErr` on a stored word comes out as `txErr` with that nibble. `txErr` is never high while `txValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both enable domains |
| rst | input | 1 | Synchronous reset, active high |
| rxCe | input | 1 | Receive-side clock enable |
| rxData | input | 4 | Incoming nibble |
| rxValid | input | 1 | Incoming frame valid |
| rxErr | input | 1 | Incoming error flag |
| txCe | input | 1 | Transmit-side clock enable |
| txData | output | 4 | Outgoing nibble, 0 when idle or starved |
| txValid | output | 1 | Outgoing frame valid |
| txErr | output | 1 | Outgoing error flag |
| fill | output | $clog2(DEPTH+1) | Number of stored entries, end markers included |

## Verification
The main frame path is driven with both enables active on every cycle. This separates the watermark hold-off from the steady state, in which one word is stored and one removed on each edge and `fill` stays flat. A short frame loaded with the transmit enable off shows that the start rule uses the stored end marker rather than the margin. Gaps in the transmit enable show that the outputs hold between enables. A starved frame and an overfilled frame use opposite enable imbalances. The first shows the sticky underrun error. The second shows the dropped words, the error mark on the last kept nibble and the reserved marker slot.

// File: rtl/mii_efifo_pkg.sv
package mii_efifo_pkg;

  typedef struct packed {
    logic       valid;
    logic       err;
    logic [3:0] data;
  } nibWord_t;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_HEAD  = 2'd1,
    OUT_UNDER = 2'd2
  } outSel_e;

  typedef struct packed {
    logic    pop;
    logic    push;
    logic    markErr;
    logic    outLoad;
    logic    forceErr;
    outSel_e outSel;
  } fifoStrobe_t;

endpackage

// File: rtl/mii_efifo_datapath.sv
module mii_efifo_datapath
  import mii_efifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  fifoStrobe_t    strobe,
  input  logic [IW-1:0]  wrIdx,
  input  logic [IW-1:0]  errIdx,
  input  nibWord_t       inWord,
  output nibWord_t       headWord,
  output logic [3:0]     outData,
  output logic           outValid,
  output logic           outErr
);

  nibWord_t stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    nibWord_t shifted;
    nibWord_t nxt;

    if (i == DEPTH - 1) begin : g_tail
      assign shifted = '0;
    end else begin : g_body
      assign shifted = stage[i+1];
    end

    always_comb begin
      nxt = strobe.pop ? shifted : stage[i];
      if (strobe.push && (wrIdx == IW'(i))) begin
        nxt = inWord;
      end
      if (strobe.markErr && (errIdx == IW'(i))) begin
        nxt.err = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage[i] <= '0;
      end else begin
        stage[i] <= nxt;
      end
    end
  end

  assign headWord = stage[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
      outErr   <= 1'b0;
    end else if (strobe.outLoad) begin
      case (strobe.outSel)
        OUT_HEAD: begin
          outData  <= stage[0].data;
          outValid <= 1'b1;
          outErr   <= stage[0].err | strobe.forceErr;
        end
        OUT_UNDER: begin
          outData  <= '0;
          outValid <= 1'b1;
          outErr   <= 1'b1;
        end
        default: begin
          outData  <= '0;
          outValid <= 1'b0;
          outErr   <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mii_efifo_control.sv
module mii_efifo_control
  import mii_efifo_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WATERMARK = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxCe,
  input  logic          rxValid,
  input  logic          txCe,
  input  nibWord_t      headWord,
  output fifoStrobe_t   strobe,
  output logic [IW-1:0] wrIdx,
  output logic [IW-1:0] errIdx,
  output logic [CW-1:0] count
);

  logic [CW-1:0] markers;
  logic          running;
  logic          underFlag;
  logic          lastRx;

  logic          goOut;
  logic          want;
  logic          fits;
  logic [CW-1:0] cntAfterPop;

  always_comb begin
    goOut = running ||
            ((count != '0) && ((count >= CW'(WATERMARK)) || (markers != '0)));

    strobe          = '0;
    strobe.outLoad  = txCe;
    strobe.forceErr = underFlag;
    strobe.pop      = txCe && goOut && (count != '0);

    if (!goOut) begin
      strobe.outSel = OUT_IDLE;
    end else if (count == '0) begin
      strobe.outSel = OUT_UNDER;
    end else if (headWord.valid) begin
      strobe.outSel = OUT_HEAD;
    end else begin
      strobe.outSel = OUT_IDLE;
    end

    cntAfterPop = count - CW'(strobe.pop);
    want        = rxCe && (rxValid || lastRx);
    fits        = rxValid ? (cntAfterPop < CW'(DEPTH - 1))
                          : (cntAfterPop < CW'(DEPTH));
    strobe.push    = want && fits;
    strobe.markErr = want && rxValid && !fits;
    wrIdx          = IW'(cntAfterPop);
    errIdx         = IW'(cntAfterPop - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      markers   <= '0;
      running   <= 1'b0;
      underFlag <= 1'b0;
      lastRx    <= 1'b0;
    end else begin
      count   <= count + CW'(strobe.push) - CW'(strobe.pop);
      markers <= markers + CW'(strobe.push && !rxValid)
                         - CW'(strobe.pop && !headWord.valid);
      if (rxCe) begin
        lastRx <= rxValid;
      end
      if (txCe && goOut) begin
        if (count == '0) begin
          running   <= 1'b1;
          underFlag <= 1'b1;
        end else if (headWord.valid) begin
          running <= 1'b1;
        end else begin
          running   <= 1'b0;
          underFlag <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mii_elastic_fifo.sv
module mii_elastic_fifo
  import mii_efifo_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WATERMARK = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxCe,
  input  logic [3:0]    rxData,
  input  logic          rxValid,
  input  logic          rxErr,
  input  logic          txCe,
  output logic [3:0]    txData,
  output logic          txValid,
  output logic          txErr,
  output logic [CW-1:0] fill
);

  fifoStrobe_t   strobe;
  logic [IW-1:0] wrIdx;
  logic [IW-1:0] errIdx;
  nibWord_t      headWord;
  nibWord_t      inWord;

  assign inWord.valid = rxValid;
  assign inWord.err   = rxValid & rxErr;
  assign inWord.data  = rxValid ? rxData : 4'h0;

  mii_efifo_control #(
    .DEPTH     (DEPTH),
    .WATERMARK (WATERMARK)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rxCe     (rxCe),
    .rxValid  (rxValid),
    .txCe     (txCe),
    .headWord (headWord),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .errIdx   (errIdx),
    .count    (fill)
  );

  mii_efifo_datapath #(
    .DEPTH (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .errIdx   (errIdx),
    .inWord   (inWord),
    .headWord (headWord),
    .outData  (txData),
    .outValid (txValid),
    .outErr   (txErr)
  );

endmodule

// File: rtl/mii_elastic_fifo_chk.sv
module mii_elastic_fifo_chk #(
  parameter int DEPTH     = 8,
  parameter int WATERMARK = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          txCe,
  input logic [3:0]    txData,
  input logic          txValid,
  input logic          txErr,
  input logic [CW-1:0] fill
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!txValid && !txErr && fill == '0));

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!txCe && !rst) |-> ($stable(txValid) && $stable(txErr) && $stable(txData)));

  p_err_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    txErr |-> txValid);

  p_underrun_err_r6: assert property (@(posedge clk) disable iff (rst)
    (txCe && txValid && fill == '0) |=> (txValid && txErr && txData == 4'h0));

endmodule

bind mii_elastic_fifo mii_elastic_fifo_chk #(
  .DEPTH     (DEPTH),
  .WATERMARK (WATERMARK)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .txCe    (txCe),
  .txData  (txData),
  .txValid (txValid),
  .txErr   (txErr),
  .fill    (fill)
);

// File: tb/mii_elastic_fifo_tb.sv
module mii_elastic_fifo_tb;

  localparam int DEPTH = 8;
  localparam int WATERMARK = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rxCe = 1'b0;
  logic [3:0]    rxData = '0;
  logic          rxValid = 1'b0;
  logic          rxErr = 1'b0;
  logic          txCe = 1'b0;
  logic [3:0]    txData;
  logic          txValid;
  logic          txErr;
  logic [CW-1:0] fill;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mii_elastic_fifo #(.DEPTH(DEPTH), .WATERMARK(WATERMARK)) u_dut (
    .clk(clk), .rst(rst), .rxCe(rxCe), .rxData(rxData), .rxValid(rxValid),
    .rxErr(rxErr), .txCe(txCe), .txData(txData), .txValid(txValid),
    .txErr(txErr), .fill(fill)
  );

  typedef struct packed {
    logic       rce;
    logic       rv;
    logic       re;
    logic [3:0] rd;
    logic       tce;
    logic       ev;
    logic       ee;
    logic [3:0] ed;
    logic [3:0] ef;
  } vec_t;

  // One frame, both enables on every cycle; nibble 3 carries an error.
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b1, 1'b0, 4'h1, 1'b1, 1'b0, 1'b0, 4'h0, 4'd1},
    '{1'b1, 1'b1, 1'b0, 4'h2, 1'b1, 1'b0, 1'b0, 4'h0, 4'd2},
    '{1'b1, 1'b1, 1'b1, 4'h3, 1'b1, 1'b0, 1'b0, 4'h0, 4'd3},
    '{1'b1, 1'b1, 1'b0, 4'h4, 1'b1, 1'b0, 1'b0, 4'h0, 4'd4},
    '{1'b1, 1'b1, 1'b0, 4'h5, 1'b1, 1'b1, 1'b0, 4'h1, 4'd4},
    '{1'b1, 1'b1, 1'b0, 4'h6, 1'b1, 1'b1, 1'b0, 4'h2, 4'd4},
    '{1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 4'h3, 4'd4},
    '{1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'h4, 4'd3},
    '{1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'h5, 4'd2},
    '{1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'h6, 4'd1},
    '{1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 4'd0},
    '{1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 4'd0}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic rce, input logic rv, input logic re,
                      input logic [3:0] rd, input logic tce);
    rxCe = rce; rxValid = rv; rxErr = re; rxData = rd; txCe = tce;
    @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input string tag, input logic v, input logic e,
                           input logic [3:0] d, input int f);
    check({tag, " txValid"}, int'(txValid), int'(v));
    check({tag, " txErr"},   int'(txErr),   int'(e));
    check({tag, " txData"},  int'(txData),  int'(d));
    check({tag, " fill"},    int'(fill),    f);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    // R1: state after reset
    expectOut("R1 reset", 1'b0, 1'b0, 4'h0, 0);
    rst = 1'b0;

    // R3 R5 R8 R9: table-driven frame
    for (int i = 0; i < 12; i++) begin
      step(VEC[i].rce, VEC[i].rv, VEC[i].re, VEC[i].rd, VEC[i].tce);
      expectOut($sformatf("R3/R5/R8/R9 vec%0d", i), VEC[i].ev, VEC[i].ee,
                VEC[i].ed, int'(VEC[i].ef));
    end

    // R2: rxCe low, inputs ignored
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b1, 4'hF, 1'b0);
      expectOut("R2 no rxCe", 1'b0, 1'b0, 4'h0, 0);
    end

    // R4: short frame starts on stored end marker
    step(1'b1, 1'b1, 1'b0, 4'hA, 1'b0);
    step(1'b1, 1'b1, 1'b0, 4'hB, 1'b0);
    step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    expectOut("R4 loaded", 1'b0, 1'b0, 4'h0, 3);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R4 first", 1'b1, 1'b0, 4'hA, 2);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
    expectOut("R3 hold", 1'b1, 1'b0, 4'hA, 2);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R4 second", 1'b1, 1'b0, 4'hB, 1);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R5 end", 1'b0, 1'b0, 4'h0, 0);

    // R3: below watermark without marker, no start
    step(1'b1, 1'b1, 1'b0, 4'h7, 1'b1);
    step(1'b1, 1'b1, 1'b0, 4'h8, 1'b1);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R3 holdoff", 1'b0, 1'b0, 4'h0, 2);
    step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R4 late start", 1'b1, 1'b0, 4'h7, 2);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R5 end2", 1'b0, 1'b0, 4'h0, 0);

    // R6: underrun
    for (int i = 1; i <= 4; i++) step(1'b1, 1'b1, 1'b0, 4'(i), 1'b0);
    for (int i = 1; i <= 4; i++) begin
      step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
      expectOut("R6 drain", 1'b1, 1'b0, 4'(i), 4 - i);
    end
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R6 starve", 1'b1, 1'b1, 4'h0, 0);
    step(1'b1, 1'b1, 1'b0, 4'h9, 1'b0);
    expectOut("R6 refill", 1'b1, 1'b1, 4'h0, 1);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R6 sticky", 1'b1, 1'b1, 4'h9, 0);
    step(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R6 starve2", 1'b1, 1'b1, 4'h0, 1);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R6 end", 1'b0, 1'b0, 4'h0, 0);

    // R7: overflow
    for (int i = 1; i <= 9; i++) begin
      step(1'b1, 1'b1, 1'b0, 4'(i), 1'b0);
      check("R7 fill", int'(fill), (i < DEPTH - 1) ? i : DEPTH - 1);
    end
    step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    check("R7 marker slot", int'(fill), DEPTH);
    for (int i = 1; i <= 7; i++) begin
      step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
      expectOut("R7 drain", 1'b1, (i == 7), 4'(i), DEPTH - i);
    end
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R7 end", 1'b0, 1'b0, 4'h0, 0);

    // R1: reset mid-frame
    for (int i = 1; i <= 5; i++) step(1'b1, 1'b1, 1'b0, 4'(i), 1'b0);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b1);
    expectOut("R1 pre", 1'b1, 1'b0, 4'h1, 4);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
    expectOut("R1 mid-frame", 1'b0, 1'b0, 4'h0, 0);
    rst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule